// File: doc/BRIEF.md
# Hidden Register Window Unlock Sequencer

This block sits on a CPU bus next to a peripheral whose register bank must stay out of the address map until software asks for it. It watches every bus cycle. Writes to one fixed key address are fed to a small sequence matcher. When a four-byte key arrives in order, the next byte written to the key address becomes a command:
- zero hides the bank;
- any other value shows the bank on the 256-byte page whose high address byte equals that value.

While the bank is visible, the block raises a registered select strobe for every bus access on the chosen page. The register bank itself and the translation logic it controls sit outside this block. They simply qualify their own accesses with the strobe.

The key address keeps working whether the bank is visible or hidden, so software can move the bank or hide it at any time. Key-address accesses are never routed to the bank, even when the chosen page contains the key address.

Top module: `hidden_window_unlock`

## Requirements
- R1: After a synchronous active-high reset, `win_visible` is 0 and `reg_sel` stays 0 for every address until an unlock completes.
- R2: Five writes to the key address `0xC0FF` with data `0x55`, `0xAA`, `0xFF`, `0x00` and then a nonzero byte N set `win_visible` to 1 and `win_base` to N. Both are observable after the clock edge that takes the fifth write.
- R3: While visible, an access whose address bits [15:8] equal `win_base` gives `reg_sel` = 1 after the clock edge that takes that access (one register of latency). An access to any other page gives `reg_sel` = 0.
- R4: A completed key followed by a fifth byte of `0x00` clears `win_visible`, after which `reg_sel` stays 0 on every page.
- R5: A write to the key address with a byte that is not the next expected key byte, and is not `0x55`, returns the matcher to its start. A further three bytes `0xFF`, `0x00`, N then change nothing.
- R6: A wrong byte equal to `0x55` at any key step counts as the first key byte. For example, `55 AA 55 AA FF 00 N` moves the bank to N.
- R7: Writes to other addresses, and reads of the key address, between key bytes neither advance nor break the sequence.
- R8: An access to the key address never raises `reg_sel`, even when `win_base` is `0xC0`. Key writes still operate while the bank is visible.
- R9: The fifth byte ends the command. A further single write to the key address, zero or nonzero, leaves `win_visible` and `win_base` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-cycle clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | CPU address for this bus cycle |
| bus_data | input | 8 | CPU write data for this bus cycle |
| bus_wr | input | 1 | High when this bus cycle is a write |
| reg_sel | output | 1 | Registered select for the register bank page |
| win_visible | output | 1 | Register bank currently mapped |
| win_base | output | 8 | High address byte of the register bank page |

## Verification
The two functions that can meet in one cycle are key matching and page decoding. This happens when the bank has been moved to page `0xC0`, so the key address lies inside the decoded page. The bench relocates the bank there, then accesses `0xC0FF` and a neighbouring address on that page. It expects no select for the key address, a select for the neighbour, and, for a key sequence written while the bank is mapped over the key, the hide command to take effect normally. Interleaved foreign writes and key-address reads between key bytes check that the matcher only counts real key writes.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  localparam int KEY_LEN = 4;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_K1   = 3'd1,
    ST_K2   = 3'd2,
    ST_K3   = 3'd3,
    ST_ARM  = 3'd4
  } step_t;

  function automatic logic [7:0] key_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    key_byte = 8'h55;
      2'd1:    key_byte = 8'hAA;
      2'd2:    key_byte = 8'hFF;
      default: key_byte = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/unlock_key_matcher.sv
module unlock_key_matcher
  import unlock_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 16'hC0FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_wr,
  output logic              cmd_valid,
  output logic [DATA_W-1:0] cmd_data
);
  step_t step_q, step_d;
  logic  key_hit;
  logic  byte_ok;
  logic  byte_restart;

  assign key_hit      = bus_wr && (bus_addr == KEY_ADDR);
  assign byte_ok      = (bus_data[7:0] == key_byte(step_q[1:0]));
  assign byte_restart = (bus_data[7:0] == key_byte(2'd0));

  always_comb begin
    step_d = step_q;
    if (key_hit) begin
      if (step_q == ST_ARM)
        step_d = ST_IDLE;
      else if (byte_ok)
        step_d = step_t'(step_q + 3'd1);
      else if (byte_restart)
        step_d = ST_K1;
      else
        step_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_IDLE;
    else     step_q <= step_d;
  end

  assign cmd_valid = key_hit && (step_q == ST_ARM);
  assign cmd_data  = bus_data;

  // R7: nothing but a key-address write moves the matcher
  a_r7_stray_stable: assert property (@(posedge clk) disable iff (rst)
    !key_hit |=> $stable(step_q));

  // R5: a wrong non-restart byte sends the matcher back to the start
  a_r5_wrong_to_idle: assert property (@(posedge clk) disable iff (rst)
    (key_hit && step_q != ST_ARM && !byte_ok && !byte_restart) |=> step_q == ST_IDLE);

  // R6: a wrong 0x55 counts as the first key byte
  a_r6_restart_k1: assert property (@(posedge clk) disable iff (rst)
    (key_hit && step_q != ST_ARM && !byte_ok && byte_restart) |=> step_q == ST_K1);

  // R9: the command byte ends the sequence
  a_r9_cmd_consumed: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |=> step_q == ST_IDLE);
endmodule

// File: rtl/unlock_window_reg.sv
module unlock_window_reg #(
  parameter int DATA_W = 8,
  parameter int BASE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [DATA_W-1:0] cmd_data,
  output logic              visible,
  output logic [BASE_W-1:0] base
);
  logic cmd_show;

  assign cmd_show = (cmd_data[BASE_W-1:0] != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      visible <= 1'b0;
      base    <= '0;
    end else if (cmd_valid) begin
      visible <= cmd_show;
      if (cmd_show) base <= cmd_data[BASE_W-1:0];
    end
  end

  // R4: a zero command hides the bank
  a_r4_hide: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_show) |=> !visible);

  // R2: a nonzero command shows the bank at that page
  a_r2_show: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_show) |=> (visible && base == $past(cmd_data[BASE_W-1:0])));

  // R9: without a command the window holds
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> ($stable(visible) && $stable(base)));
endmodule

// File: rtl/unlock_page_decode.sv
module unlock_page_decode #(
  parameter int ADDR_W = 16,
  parameter int BASE_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 16'hC0FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              visible,
  input  logic [BASE_W-1:0] base,
  output logic              reg_sel
);
  logic page_hit;
  logic key_access;

  assign page_hit   = (bus_addr[ADDR_W-1 -: BASE_W] == base);
  assign key_access = (bus_addr == KEY_ADDR);

  always_ff @(posedge clk) begin
    if (rst) reg_sel <= 1'b0;
    else     reg_sel <= visible && page_hit && !key_access;
  end

  // R1/R4: a hidden bank is never selected
  a_r4_no_sel_hidden: assert property (@(posedge clk) disable iff (rst)
    !visible |=> !reg_sel);

  // R8: the key address is never routed to the bank
  a_r8_key_no_sel: assert property (@(posedge clk) disable iff (rst)
    key_access |=> !reg_sel);
endmodule

// File: rtl/hidden_window_unlock.sv
module hidden_window_unlock #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 16'hC0FF
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_data,
  input  logic                     bus_wr,
  output logic                     reg_sel,
  output logic                     win_visible,
  output logic [ADDR_W-PAGE_W-1:0] win_base
);
  localparam int BASE_W = ADDR_W - PAGE_W;

  logic              cmd_valid;
  logic [DATA_W-1:0] cmd_data;

  unlock_key_matcher #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR)
  ) u_match (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_wr(bus_wr), .cmd_valid(cmd_valid), .cmd_data(cmd_data)
  );

  unlock_window_reg #(
    .DATA_W(DATA_W), .BASE_W(BASE_W)
  ) u_win (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .visible(win_visible), .base(win_base)
  );

  unlock_page_decode #(
    .ADDR_W(ADDR_W), .BASE_W(BASE_W), .KEY_ADDR(KEY_ADDR)
  ) u_dec (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .visible(win_visible),
    .base(win_base), .reg_sel(reg_sel)
  );

  // R1: hidden straight out of reset
  a_r1_hidden_at_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!win_visible && !reg_sel));
endmodule

// File: tb/test_hidden_window_unlock.sv
module test_hidden_window_unlock;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_data = 8'h00;
  logic        bus_wr = 1'b0;
  logic        reg_sel;
  logic        win_visible;
  logic [7:0]  win_base;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  hidden_window_unlock i_hidden_window_unlock (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_wr(bus_wr), .reg_sel(reg_sel), .win_visible(win_visible),
    .win_base(win_base)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus cycle; returns after the edge that takes it
  task automatic cyc(input logic [15:0] a, input logic [7:0] d, input logic w);
    @(negedge clk);
    bus_addr = a; bus_data = d; bus_wr = w;
    @(posedge clk);
    #1;
    bus_addr = 16'h0000; bus_wr = 1'b0; bus_data = 8'h00;
  endtask

  task automatic key(input logic [7:0] d);
    cyc(16'hC0FF, d, 1'b1);
  endtask

  task automatic unlock(input logic [7:0] n);
    key(8'h55); key(8'hAA); key(8'hFF); key(8'h00); key(n);
  endtask

  task automatic t_reset;
    check("R1 visible", {15'd0, win_visible}, 16'd0);
    cyc(16'h0012, 8'h00, 1'b0);
    check("R1 sel page00", {15'd0, reg_sel}, 16'd0);
    cyc(16'hC0FF, 8'h00, 1'b0);
    check("R1 sel key", {15'd0, reg_sel}, 16'd0);
  endtask

  task automatic t_unlock;
    unlock(8'hD4);
    check("R2 visible", {15'd0, win_visible}, 16'd1);
    check("R2 base", {8'd0, win_base}, 16'h00D4);
    cyc(16'hD412, 8'h00, 1'b0);
    check("R3 sel in page", {15'd0, reg_sel}, 16'd1);
    cyc(16'hD3FF, 8'h00, 1'b0);
    check("R3 sel below", {15'd0, reg_sel}, 16'd0);
    cyc(16'hD500, 8'h00, 1'b1);
    check("R3 sel above", {15'd0, reg_sel}, 16'd0);
    cyc(16'hD4FF, 8'h33, 1'b1);
    check("R3 sel write", {15'd0, reg_sel}, 16'd1);
  endtask

  task automatic t_wrong;
    key(8'h55); key(8'hAA); key(8'h12); key(8'hFF); key(8'h00); key(8'hD6);
    check("R5 base kept", {8'd0, win_base}, 16'h00D4);
    check("R5 visible kept", {15'd0, win_visible}, 16'd1);
    key(8'h55); key(8'hAA); key(8'h55); key(8'hAA); key(8'hFF); key(8'h00); key(8'hD6);
    check("R6 base", {8'd0, win_base}, 16'h00D6);
    key(8'h55); key(8'h55); key(8'hAA); key(8'hFF); key(8'h00); key(8'hD8);
    check("R6 double 55", {8'd0, win_base}, 16'h00D8);
  endtask

  task automatic t_interleave;
    key(8'h55);
    cyc(16'h1234, 8'hAA, 1'b1);
    cyc(16'hC0FF, 8'h00, 1'b0);
    key(8'hAA);
    cyc(16'hC0FE, 8'h12, 1'b1);
    key(8'hFF);
    cyc(16'hD800, 8'h99, 1'b1);
    key(8'h00);
    cyc(16'hC0FF, 8'h00, 1'b0);
    key(8'h9A);
    check("R7 base", {8'd0, win_base}, 16'h009A);
  endtask

  task automatic t_key_in_window;
    unlock(8'hC0);
    check("R8 base C0", {8'd0, win_base}, 16'h00C0);
    cyc(16'hC0FF, 8'h00, 1'b0);
    check("R8 key read no sel", {15'd0, reg_sel}, 16'd0);
    key(8'h21);
    check("R8 key write no sel", {15'd0, reg_sel}, 16'd0);
    cyc(16'hC010, 8'h00, 1'b0);
    check("R8 neighbour sel", {15'd0, reg_sel}, 16'd1);
    unlock(8'h00);
    check("R4 hidden", {15'd0, win_visible}, 16'd0);
    cyc(16'hC010, 8'h00, 1'b0);
    check("R4 no sel", {15'd0, reg_sel}, 16'd0);
  endtask

  task automatic t_consume;
    unlock(8'h40);
    check("R9 base 40", {8'd0, win_base}, 16'h0040);
    key(8'h77);
    check("R9 base held", {8'd0, win_base}, 16'h0040);
    key(8'h00);
    check("R9 visible held", {15'd0, win_visible}, 16'd1);
    cyc(16'h4001, 8'h00, 1'b0);
    check("R9 sel still", {15'd0, reg_sel}, 16'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_unlock();
    t_wrong();
    t_interleave();
    t_key_in_window();
    t_consume();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule